// File: doc/BRIEF.md
# Ordered Store Buffer with Fence Control

This block sits between a core's store issue and a memory write port. Stores go into a small private queue and the core moves on at once. The queue writes its entries to memory in the background, one line-sized write at a time, under a valid/ready handshake. Loads can run ahead of stores that are still queued. A load looks up the queue and takes the youngest queued copy of its word, so it never sees the stale value in memory.

A mode input picks the drain order. In strict mode (`psoMode` = 0) entries drain oldest first and each store keeps its own entry. In relaxed mode (`psoMode` = 1) a store merges into the youngest entry when both hit the same line. A completely filled line may also drain ahead of older entries, provided no older entry holds that line. A fence request input accepts three fence kinds, and each kind stalls the store and load inputs by its own rule. A flag shows when the queue is empty.

Addresses are word addresses. The upper bits select the line and the low `log2(LINE_WORDS)` bits select the word within the line.

Top module: `stbuf_top`

## Requirements
- R1: After reset `bufEmpty` = 1, `memValid` = 0 and `stReady` = 1. Once a store is accepted, `bufEmpty` is 0 and `memValid` is 1 from the next cycle until the queue drains.
- R2: When `psoMode` = 0, every accepted store gets its own entry. Entries reach the memory port in acceptance order, each with a one-hot `memMask` (bit w = word w). Unwritten words of `memData` are zero.
- R3: When `psoMode` = 1, a store whose line equals the youngest entry's line merges into that entry: it sets that word's mask bit and overwrites that word. The one exception is a cycle in which that youngest entry is being written out; the store then takes a new entry.
- R4: When `psoMode` = 1, the port offers the oldest entry whose mask is all ones and that has no older entry with the same line. If no entry qualifies, it offers the oldest entry.
- R5: When `ldValid` = 1 and some entry holds the load's word, `ldHit` = 1 and `ldData` is that word from the youngest such entry. Otherwise both are 0.
- R6: `stReady` drops when all ENTRIES are in use and the store cannot merge. When not full, a store and a memory write in the same cycle both take effect.
- R7: An entry is removed only in a cycle with `memValid` and `memReady` both high. While `memReady` is low in strict mode, `memLine`, `memData` and `memMask` hold.
- R8: While `fenceValid` = 1 with `fenceKind` 0 or 3 (full fence), `stReady` = 0 and `ldReady` = 0. `fenceDone` is 1 only when the queue is empty.
- R9: While `fenceValid` = 1 with `fenceKind` = 1 (store fence), `stReady` = 0 and `ldReady` = 1. `fenceDone` is 1 only when the queue is empty.
- R10: With `fenceKind` = 2 (load fence), `fenceDone` is 1 at once even when entries remain. `stReady`, `ldReady` and draining are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psoMode | input | 1 | 0 strict oldest-first drain, 1 relaxed drain with merging |
| stValid | input | 1 | Store request |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data |
| stReady | output | 1 | Store accepted when high with stValid |
| ldValid | input | 1 | Load lookup request |
| ldAddr | input | ADDR_W | Load word address |
| ldReady | output | 1 | Load may issue |
| ldHit | output | 1 | Load word found in the queue |
| ldData | output | DATA_W | Forwarded word |
| fenceValid | input | 1 | Fence request held until done |
| fenceKind | input | 2 | 0/3 full, 1 store, 2 load |
| fenceDone | output | 1 | Fence condition met |
| memValid | output | 1 | Line write offered |
| memReady | input | 1 | Memory accepts the write |
| memLine | output | ADDR_W-log2(LINE_WORDS) | Line index of the write |
| memData | output | DATA_W*LINE_WORDS | Line data, word w at bits w*DATA_W |
| memMask | output | LINE_WORDS | Per-word write enable |
| bufEmpty | output | 1 | Queue holds no entries |

## Verification
Errors in the entry count, an entry out of place, or a bad merge show up within the same cycle on `memLine`, `memMask` or `ldData`. They also show on `stReady` or `bufEmpty`, which follow the count directly. A removal that skipped the handshake shows as a missing or repeated line write as soon as the port advances. A merge into the wrong entry shows on a load to that word in the next cycle. Fence errors show on the ready outputs in the same cycle as the request. Because of this, the bench compares every output each cycle against its own queue model instead of waiting for the end of the run.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  // strobes from the control to the entry array
  typedef struct packed {
    logic push;   // store accepted this cycle
    logic merge;  // accepted store joins youngest entry
    logic pop;    // entry at popIdx written to memory
  } sbStrobe_t;

  localparam logic [1:0] FENCE_FULL  = 2'd0;
  localparam logic [1:0] FENCE_STORE = 2'd1;
  localparam logic [1:0] FENCE_LOAD  = 2'd2;
  localparam logic [1:0] FENCE_FULL2 = 2'd3;
endpackage

// File: rtl/stbuf_data.sv
module stbuf_data
  import stbuf_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int LINE_W  = ADDR_W - OFF_W,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CNT_W   = $clog2(ENTRIES + 1),
  localparam int LDATA_W = DATA_W * LINE_WORDS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sbStrobe_t             stb,
  input  logic [IDX_W-1:0]      popIdx,
  input  logic [ADDR_W-1:0]     stAddr,
  input  logic [DATA_W-1:0]     stData,
  input  logic                  ldValid,
  input  logic [ADDR_W-1:0]     ldAddr,
  output logic [CNT_W-1:0]      cnt,
  output logic [ENTRIES-1:0]    fullVec,
  output logic [ENTRIES-1:0]    olderSameVec,
  output logic                  youngLineHit,
  output logic [LINE_W-1:0]     memLine,
  output logic [LDATA_W-1:0]    memData,
  output logic [LINE_WORDS-1:0] memMask,
  output logic                  ldHit,
  output logic [DATA_W-1:0]     ldData
);

  logic [LINE_W-1:0]     eLine [ENTRIES];
  logic [LDATA_W-1:0]    eData [ENTRIES];
  logic [LINE_WORDS-1:0] eMask [ENTRIES];
  logic [CNT_W-1:0]      cntQ;

  logic [LINE_W-1:0]     nLine [ENTRIES];
  logic [LDATA_W-1:0]    nData [ENTRIES];
  logic [LINE_WORDS-1:0] nMask [ENTRIES];
  logic [CNT_W-1:0]      nCnt, cntAfterPop;

  logic [LINE_W-1:0] stLine, ldLine;
  logic [OFF_W-1:0]  stWord, ldWord;

  assign stLine = stAddr[ADDR_W-1:OFF_W];
  assign stWord = stAddr[OFF_W-1:0];
  assign ldLine = ldAddr[ADDR_W-1:OFF_W];
  assign ldWord = ldAddr[OFF_W-1:0];
  assign cnt    = cntQ;

  // next state: removal compacts the queue, then the store lands
  always_comb begin
    nLine = eLine;
    nData = eData;
    nMask = eMask;
    cntAfterPop = cntQ;
    if (stb.pop) begin
      cntAfterPop = cntQ - 1'b1;
      for (int i = 0; i < ENTRIES - 1; i++) begin
        if (i >= int'(popIdx)) begin
          nLine[i] = eLine[i+1];
          nData[i] = eData[i+1];
          nMask[i] = eMask[i+1];
        end
      end
    end
    nCnt = cntAfterPop;
    if (stb.push) begin
      if (stb.merge) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (i == int'(cntAfterPop) - 1) begin
            for (int w = 0; w < LINE_WORDS; w++) begin
              if (w == int'(stWord)) begin
                nData[i][w*DATA_W +: DATA_W] = stData;
                nMask[i][w] = 1'b1;
              end
            end
          end
        end
      end else begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (i == int'(cntAfterPop)) begin
            nLine[i] = stLine;
            nData[i] = '0;
            nMask[i] = '0;
            for (int w = 0; w < LINE_WORDS; w++) begin
              if (w == int'(stWord)) begin
                nData[i][w*DATA_W +: DATA_W] = stData;
                nMask[i][w] = 1'b1;
              end
            end
          end
        end
        nCnt = cntAfterPop + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        eLine[i] <= '0;
        eData[i] <= '0;
        eMask[i] <= '0;
      end
    end else begin
      cntQ  <= nCnt;
      eLine <= nLine;
      eData <= nData;
      eMask <= nMask;
    end
  end

  // per-entry status for the drain picker
  for (genvar g = 0; g < ENTRIES; g++) begin : gEnt
    logic olderHit;
    always_comb begin
      olderHit = 1'b0;
      for (int j = 0; j < g; j++) begin
        if (eLine[j] == eLine[g]) olderHit = 1'b1;
      end
    end
    assign fullVec[g]      = (g < int'(cntQ)) && (&eMask[g]);
    assign olderSameVec[g] = olderHit;
  end

  always_comb begin
    youngLineHit = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (i == int'(cntQ) - 1 && eLine[i] == stLine) youngLineHit = 1'b1;
    end
  end

  // forwarding: later (younger) matches override earlier ones
  always_comb begin
    ldHit  = 1'b0;
    ldData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      for (int w = 0; w < LINE_WORDS; w++) begin
        if (ldValid && i < int'(cntQ) && eLine[i] == ldLine &&
            w == int'(ldWord) && eMask[i][w]) begin
          ldHit  = 1'b1;
          ldData = eData[i][w*DATA_W +: DATA_W];
        end
      end
    end
  end

  assign memLine = eLine[popIdx];
  assign memData = eData[popIdx];
  assign memMask = eMask[popIdx];

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(cntQ) <= ENTRIES);

  // R3
  merge_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.push && stb.merge && !stb.pop |=> cntQ == $past(cntQ));

  // R1
  empty_stays_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ == '0 && !stb.push |=> cntQ == '0);

endmodule

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl
  import stbuf_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               psoMode,
  input  logic               stValid,
  input  logic               fenceValid,
  input  logic [1:0]         fenceKind,
  input  logic               memReady,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [ENTRIES-1:0] fullVec,
  input  logic [ENTRIES-1:0] olderSameVec,
  input  logic               youngLineHit,
  output sbStrobe_t          stb,
  output logic [IDX_W-1:0]   popIdx,
  output logic               memValid,
  output logic               stReady,
  output logic               ldReady,
  output logic               fenceDone,
  output logic               bufEmpty
);

  logic pick_found, mergeOk, youngestPicked, fullFence, storeFence;
  logic [IDX_W-1:0] pick;

  // relaxed mode: first complete line with no older same-line entry
  always_comb begin
    pick = '0;
    pick_found = 1'b0;
    if (psoMode) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!pick_found && fullVec[i] && !olderSameVec[i]) begin
          pick = IDX_W'(i);
          pick_found = 1'b1;
        end
      end
    end
  end

  assign popIdx   = pick;
  assign bufEmpty = (cnt == '0);
  assign memValid = !bufEmpty;
  assign stb.pop  = memValid && memReady;

  assign youngestPicked = (int'(pick) == int'(cnt) - 1);
  assign mergeOk = psoMode && youngLineHit && !(stb.pop && youngestPicked);

  assign fullFence  = fenceValid && (fenceKind == FENCE_FULL || fenceKind == FENCE_FULL2);
  assign storeFence = fenceValid && (fenceKind == FENCE_STORE);

  assign stReady   = !fullFence && !storeFence && ((cnt != CNT_W'(ENTRIES)) || mergeOk);
  assign ldReady   = !fullFence;
  assign fenceDone = fenceValid && (fenceKind == FENCE_LOAD || bufEmpty);

  assign stb.push  = stValid && stReady;
  assign stb.merge = stb.push && mergeOk;

  // R7
  pop_frees_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && !stb.push |=> int'(cnt) == int'($past(cnt)) - 1);

  // R6
  push_grows_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.push && !stb.merge && !stb.pop |=> int'(cnt) == int'($past(cnt)) + 1);

  // R6
  push_pop_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.push && !stb.merge && stb.pop |=> cnt == $past(cnt));

endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
  import stbuf_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int LINE_W  = ADDR_W - OFF_W,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CNT_W   = $clog2(ENTRIES + 1),
  localparam int LDATA_W = DATA_W * LINE_WORDS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  psoMode,
  input  logic                  stValid,
  input  logic [ADDR_W-1:0]     stAddr,
  input  logic [DATA_W-1:0]     stData,
  output logic                  stReady,
  input  logic                  ldValid,
  input  logic [ADDR_W-1:0]     ldAddr,
  output logic                  ldReady,
  output logic                  ldHit,
  output logic [DATA_W-1:0]     ldData,
  input  logic                  fenceValid,
  input  logic [1:0]            fenceKind,
  output logic                  fenceDone,
  output logic                  memValid,
  input  logic                  memReady,
  output logic [LINE_W-1:0]     memLine,
  output logic [LDATA_W-1:0]    memData,
  output logic [LINE_WORDS-1:0] memMask,
  output logic                  bufEmpty
);

  sbStrobe_t          stb;
  logic [IDX_W-1:0]   popIdx;
  logic [CNT_W-1:0]   cnt;
  logic [ENTRIES-1:0] fullVec, olderSameVec;
  logic               youngLineHit;

  stbuf_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .psoMode(psoMode), .stValid(stValid),
    .fenceValid(fenceValid), .fenceKind(fenceKind), .memReady(memReady),
    .cnt(cnt), .fullVec(fullVec), .olderSameVec(olderSameVec),
    .youngLineHit(youngLineHit), .stb(stb), .popIdx(popIdx),
    .memValid(memValid), .stReady(stReady), .ldReady(ldReady),
    .fenceDone(fenceDone), .bufEmpty(bufEmpty)
  );

  stbuf_data #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
               .LINE_WORDS(LINE_WORDS)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .popIdx(popIdx),
    .stAddr(stAddr), .stData(stData), .ldValid(ldValid), .ldAddr(ldAddr),
    .cnt(cnt), .fullVec(fullVec), .olderSameVec(olderSameVec),
    .youngLineHit(youngLineHit), .memLine(memLine), .memData(memData),
    .memMask(memMask), .ldHit(ldHit), .ldData(ldData)
  );

  // R7
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !psoMode && memValid && !memReady |=>
      psoMode || (memValid && $stable(memLine) && $stable(memMask) && $stable(memData)));

endmodule

// File: tb/stbuf_top_tb_top.sv
module stbuf_top_tb_top;
  localparam int N = 4, AW = 8, DW = 16, LW = 4;
  localparam int OW = 2, LNW = AW - OW, LDW = DW * LW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic pso = 1'b0, modeReq = 1'b0;
  logic sv = 0, lv = 0, mr = 0, fv = 0;
  logic [AW-1:0] sa = '0, la = '0;
  logic [DW-1:0] sd = '0;
  logic [1:0] fk = '0;
  logic stReady, ldReady, ldHit, fenceDone, memValid, bufEmpty;
  logic [DW-1:0] ldData;
  logic [LNW-1:0] memLine;
  logic [LDW-1:0] memData;
  logic [LW-1:0] memMask;

  stbuf_top #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW)) dut_i (
    .clk(clk), .rstN(rstN), .psoMode(pso), .stValid(sv), .stAddr(sa),
    .stData(sd), .stReady(stReady), .ldValid(lv), .ldAddr(la),
    .ldReady(ldReady), .ldHit(ldHit), .ldData(ldData), .fenceValid(fv),
    .fenceKind(fk), .fenceDone(fenceDone), .memValid(memValid),
    .memReady(mr), .memLine(memLine), .memData(memData),
    .memMask(memMask), .bufEmpty(bufEmpty)
  );

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  // bench queue model
  logic [LNW-1:0] mLine [N];
  logic [LDW-1:0] mData [N];
  logic [LW-1:0]  mMask [N];
  int mCnt = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int pickIdx(logic p);
    if (p) begin
      for (int i = 0; i < mCnt; i++) begin
        bit older = 0;
        for (int j = 0; j < i; j++) if (mLine[j] == mLine[i]) older = 1;
        if ((&mMask[i]) && !older) return i;
      end
    end
    return 0;
  endfunction

  function automatic logic [AW-1:0] ad(int line, int word);
    return {LNW'(line), OW'(word)};
  endfunction

  task automatic cyc(bit sv_, logic [AW-1:0] sa_, logic [DW-1:0] sd_, bit lv_,
                     logic [AW-1:0] la_, bit mr_, bit fv_, logic [1:0] fk_);
    int pk;
    bit pop, fullF, stF, yHit, mOk, eStR, hit;
    logic [DW-1:0] ld;
    string rs, rm;
    @(negedge clk);
    pso = modeReq; sv = sv_; sa = sa_; sd = sd_; lv = lv_; la = la_;
    mr = mr_; fv = fv_; fk = fk_;
    #1;
    pk = pickIdx(pso);
    pop = (mCnt > 0) && mr_;
    yHit = (mCnt > 0) && (mLine[(mCnt > 0) ? mCnt-1 : 0] == sa_[AW-1:OW]);
    mOk = pso && yHit && !(pop && pk == mCnt - 1);
    fullF = fv_ && (fk_ == 2'd0 || fk_ == 2'd3);
    stF = fv_ && fk_ == 2'd1;
    eStR = !fullF && !stF && (mCnt < N || mOk);
    hit = 0; ld = '0;
    if (lv_) for (int i = 0; i < mCnt; i++)
      if (mLine[i] == la_[AW-1:OW] && mMask[i][la_[OW-1:0]]) begin
        hit = 1; ld = mData[i][int'(la_[OW-1:0])*DW +: DW];
      end
    rs = fullF ? "R8" : (stF ? "R9" : (fv_ ? "R10" : "R6"));
    chk(rs, "stReady", 64'(stReady), 64'(eStR));
    chk(fullF ? "R8" : "R10", "ldReady", 64'(ldReady), 64'(!fullF));
    chk(fk_ == 2'd2 ? "R10" : (fk_ == 2'd1 ? "R9" : "R8"), "fenceDone",
        64'(fenceDone), 64'(fv_ && (fk_ == 2'd2 || mCnt == 0)));
    chk("R1", "bufEmpty", 64'(bufEmpty), 64'(mCnt == 0));
    chk("R7", "memValid", 64'(memValid), 64'(mCnt > 0));
    chk("R5", "ldHit", 64'(ldHit), 64'(hit));
    chk("R5", "ldData", 64'(ldData), 64'(ld));
    if (mCnt > 0) begin
      rm = pso ? "R4" : "R2";
      chk(rm, "memLine", 64'(memLine), 64'(mLine[pk]));
      chk(rm, "memData", 64'(memData), 64'(mData[pk]));
      chk(pso ? "R3" : "R2", "memMask", 64'(memMask), 64'(mMask[pk]));
    end
    if (pop) begin
      for (int i = pk; i < N - 1; i++) begin
        mLine[i] = mLine[i+1]; mData[i] = mData[i+1]; mMask[i] = mMask[i+1];
      end
      mCnt--;
    end
    if (sv_ && eStR) begin
      int w;
      w = int'(sa_[OW-1:0]);
      if (mOk) begin
        mData[mCnt-1][w*DW +: DW] = sd_; mMask[mCnt-1][w] = 1'b1;
      end else begin
        mLine[mCnt] = sa_[AW-1:OW]; mData[mCnt] = '0; mMask[mCnt] = '0;
        mData[mCnt][w*DW +: DW] = sd_; mMask[mCnt][w] = 1'b1;
        mCnt++;
      end
    end
    @(posedge clk);
  endtask

  task automatic idle(bit mr_);
    cyc(0, '0, '0, 0, '0, mr_, 0, 2'd0);
  endtask

  task automatic randRun(int n, int sel);
    logic [AW-1:0] last;
    last = '0;
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] a, l;
      if (sel == 2 && ($urandom % 40) == 0) modeReq = ~modeReq;
      if (($urandom % 2) == 0) a = last + 1'b1;
      else a = ad(int'($urandom % 4), int'($urandom % LW));
      l = (($urandom % 2) == 0) ? last : ad(int'($urandom % 4), int'($urandom % LW));
      cyc(($urandom % 3) != 0, a, DW'($urandom), ($urandom % 2) == 0, l,
          ($urandom % 5) < 2, ($urandom % 12) == 0, 2'($urandom));
      last = a;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin mLine[i] = '0; mData[i] = '0; mMask[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1", "reset bufEmpty", 64'(bufEmpty), 64'd1);
    chk("R1", "reset memValid", 64'(memValid), 64'd0);
    chk("R1", "reset stReady", 64'(stReady), 64'd1);

    // strict mode: order, forwarding, stall hold (R2 R5 R7)
    modeReq = 0;
    cyc(1, ad(1, 0), 16'h1111, 0, '0, 0, 0, 2'd0);
    cyc(1, ad(2, 1), 16'h2222, 0, '0, 0, 0, 2'd0);
    cyc(1, ad(1, 0), 16'h3333, 1, ad(1, 0), 0, 0, 2'd0);
    cyc(0, '0, '0, 1, ad(1, 0), 0, 0, 2'd0);
    repeat (3) idle(0);
    // fill and full stall (R6)
    cyc(1, ad(3, 2), 16'h4444, 0, '0, 0, 0, 2'd0);
    cyc(1, ad(0, 3), 16'h5555, 0, '0, 0, 0, 2'd0);
    cyc(1, ad(0, 3), 16'h5555, 0, '0, 1, 0, 2'd0);
    cyc(1, ad(0, 3), 16'h6666, 0, '0, 1, 0, 2'd0);
    // full fence (R8)
    cyc(1, ad(0, 0), 16'h7777, 1, ad(0, 3), 0, 1, 2'd0);
    cyc(1, ad(0, 0), 16'h7777, 1, ad(0, 3), 0, 1, 2'd3);
    repeat (5) cyc(1, ad(0, 0), 16'h7777, 1, ad(0, 3), 1, 1, 2'd0);
    // store fence (R9)
    cyc(1, ad(2, 2), 16'h8888, 0, '0, 0, 0, 2'd0);
    cyc(1, ad(3, 3), 16'h9999, 0, '0, 0, 0, 2'd0);
    repeat (2) cyc(1, ad(1, 1), 16'haaaa, 1, ad(2, 2), 0, 1, 2'd1);
    repeat (3) cyc(1, ad(1, 1), 16'haaaa, 1, ad(2, 2), 1, 1, 2'd1);
    // load fence (R10)
    cyc(1, ad(2, 0), 16'hbbbb, 0, '0, 0, 0, 2'd0);
    repeat (2) cyc(1, ad(3, 0), 16'hcccc, 1, ad(2, 0), 0, 1, 2'd2);
    repeat (5) idle(1);

    // relaxed mode: merge and full-line priority (R3 R4)
    modeReq = 1;
    cyc(1, ad(1, 0), 16'h0101, 0, '0, 0, 0, 2'd0);
    for (int w = 0; w < LW; w++) cyc(1, ad(2, w), DW'(16'h0200 + w), 0, '0, 0, 0, 2'd0);
    cyc(1, ad(1, 1), 16'h0111, 1, ad(2, 3), 0, 0, 2'd0);
    repeat (4) idle(1);
    // merge blocked while youngest is written out (R3)
    cyc(1, ad(3, 0), 16'h0300, 0, '0, 0, 0, 2'd0);
    cyc(1, ad(3, 1), 16'h0301, 0, '0, 1, 0, 2'd0);
    repeat (3) idle(1);

    randRun(3000, 0);
    modeReq = 1;
    randRun(3000, 1);
    randRun(3000, 2);
    repeat (8) idle(1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule